// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block merges eight interrupt request lines into one interrupt output for a host processor. Three per-line bit registers track state: requests waiting for acknowledge, requests acknowledged but not yet finished, and a mask that hides lines from the processor. The processor answers the interrupt with two acknowledge strobes. The first strobe moves the winning request into service. The second strobe returns a vector number, which is a programmable base plus the line number.

Priority is either fixed, or rotating so that the line most recently finished drops to the bottom. Each line is latched on a rising edge or followed as a level, chosen per line. Service ends with a non-specific end-of-interrupt strobe, or automatically during the acknowledge sequence. A small write port with a 2-bit address holds four settings: the mode, the mask, the per-line trigger select and the vector base.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_out` and `vec_valid` are 0, nothing is pending or in service, priority is fixed, every line is edge triggered and unmasked, and the vector base is 0.
- R2: An edge-triggered line (trigger bit 0) becomes pending on a rising edge and stays pending only while it is held high. After acknowledge it does not request again until it falls and rises again.
- R3: A level-triggered line (written through address 2, bit i = 1 for line i) is pending whenever its input is high, so it requests again after its end-of-interrupt. Its request drops one cycle after the input falls.
- R4: A line whose mask bit is set (address 1, bit i for line i) never raises `int_out` and is never taken by an acknowledge, but it stays pending. Clearing the mask bit presents it.
- R5: In fixed mode line 0 has the highest priority and line 7 the lowest. Lines that request together are served in that order.
- R6: `int_out` is 1 exactly when some unmasked pending line has strictly higher priority than every line in service, so a higher line can nest above a lower one.
- R7: The first `ack_pulse` moves the winning bit from pending to in service. The second `ack_pulse` makes `vec_out` equal to base (address 3) plus the line number, modulo 256, with `vec_valid` high for one cycle after it.
- R8: An `eoi_cmd` pulse clears the highest-priority in-service bit. With nothing in service it has no effect.
- R9: With auto end-of-interrupt (address 0, bit 1) set, the in-service bit is cleared at the second acknowledge, so lower lines can interrupt without any `eoi_cmd`.
- R10: With rotating priority (address 0, bit 0) set, the line whose service just ended becomes the lowest priority, and the line after it becomes the highest.
- R11: If no unmasked request beats the lines in service at the first acknowledge, the vector returned is base plus 7 and no in-service bit is set.
- R12: When `eoi_cmd` and the first `ack_pulse` fall in the same cycle, the acknowledge is resolved against the in-service set with that end-of-interrupt already applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 2 | 0 mode, 1 mask, 2 trigger select, 3 vector base |
| cfg_wdata | input | 8 | Settings write data |
| eoi_cmd | input | 1 | Non-specific end-of-interrupt strobe |
| ack_pulse | input | 1 | Acknowledge strobe, alternating first and second phase |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned after the second acknowledge |
| vec_valid | output | 1 | One-cycle flag marking a new vector |

## Verification
An end-of-interrupt and the first acknowledge phase can land in the same clock cycle. In that cycle, the line leaving service would otherwise block a lower pending line. The bench holds line 2 in service and line 5 pending, so `int_out` is low, then raises `eoi_cmd` and `ack_pulse` together. The result is correct when the vector returned is base plus 5 rather than the spurious base plus 7, and line 5 then blocks a newly raised line 6 until one more end-of-interrupt.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef struct packed {
      logic auto_eoi;
      logic rotate;
   } pic_mode_t;

   localparam logic [1:0] CFG_MODE = 2'd0;
   localparam logic [1:0] CFG_MASK = 2'd1;
   localparam logic [1:0] CFG_TRIG = 2'd2;
   localparam logic [1:0] CFG_BASE = 2'd3;
endpackage

// File: rtl/irq_req_stage.sv
module irq_req_stage #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] level_sel,
   input  logic [N-1:0] take_clr,
   output logic [N-1:0] irr_q
);
   logic [N-1:0] irq_d;
   logic [N-1:0] irr_nxt;

   for (genvar i = 0; i < N; i++) begin : g_line
      assign irr_nxt[i] = level_sel[i]
                        ? (irq_in[i] & ~take_clr[i])
                        : (irq_in[i] & ((irr_q[i] & ~take_clr[i]) | (irq_in[i] & ~irq_d[i])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_d <= '0;
         irr_q <= '0;
      end else begin
         irq_d <= irq_in;
         irr_q <= irr_nxt;
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [IW-1:0] low_ptr,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [IW-1:0] rank;

   always_comb begin
      logic [IW-1:0] pos;
      rank = '0;
      for (int k = N - 1; k >= 0; k--) begin
         pos = low_ptr + IW'(1) + IW'(k);
         if (vec[pos]) rank = IW'(k);
      end
      any = |vec;
      idx = low_ptr + IW'(1) + rank;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned VEC_W     = 8,
   localparam int unsigned IW       = $clog2(NUM_LINES),
   localparam int unsigned CW       = (NUM_LINES > VEC_W) ? NUM_LINES : VEC_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_addr,
   input  logic [CW-1:0]        cfg_wdata,
   input  logic                 eoi_cmd,
   input  logic                 ack_pulse,
   output logic                 int_out,
   output logic [VEC_W-1:0]     vec_out,
   output logic                 vec_valid
);
   localparam logic [IW-1:0]        LAST = IW'(NUM_LINES - 1);
   localparam logic [NUM_LINES-1:0] BIT0 = {{(NUM_LINES-1){1'b0}}, 1'b1};

   if (NUM_LINES < 2 || (1 << IW) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (VEC_W < IW) begin : g_bad_vec
      $error("VEC_W too narrow for the line number");
   end

   pic_mode_t            mode_q;
   logic [NUM_LINES-1:0] mask_q, trig_q, isr_q, irr_q;
   logic [VEC_W-1:0]     base_q, vec_q;
   logic [IW-1:0]        low_q, sel_q;
   logic                 phase_q, spur_q, vld_q;

   logic [NUM_LINES-1:0] cand, eoi_hit, isr_eff, take_vec, aeoi_clr, isr_d;
   logic                 req_any, isr_any, eff_any, take_ok, first_ack, second_ack;
   logic [IW-1:0]        req_idx, isr_idx, eff_idx, low_d;

   function automatic logic [IW-1:0] rank_of(input logic [IW-1:0] idx, input logic [IW-1:0] low);
      return idx - low - IW'(1);
   endfunction

   irq_req_stage #(.N(NUM_LINES)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(trig_q),
      .take_clr(take_vec), .irr_q(irr_q)
   );

   assign cand    = irr_q & ~mask_q;
   assign eoi_hit = (eoi_cmd && isr_any) ? (BIT0 << isr_idx) : '0;
   assign isr_eff = isr_q & ~eoi_hit;

   irq_prio_pick #(.N(NUM_LINES)) u_pick_req (.vec(cand),    .low_ptr(low_q), .any(req_any), .idx(req_idx));
   irq_prio_pick #(.N(NUM_LINES)) u_pick_isr (.vec(isr_q),   .low_ptr(low_q), .any(isr_any), .idx(isr_idx));
   irq_prio_pick #(.N(NUM_LINES)) u_pick_eff (.vec(isr_eff), .low_ptr(low_q), .any(eff_any), .idx(eff_idx));

   assign int_out = req_any && (!isr_any || rank_of(req_idx, low_q) < rank_of(isr_idx, low_q));
   assign take_ok = req_any && (!eff_any || rank_of(req_idx, low_q) < rank_of(eff_idx, low_q));

   assign first_ack  = ack_pulse && !phase_q;
   assign second_ack = ack_pulse &&  phase_q;
   assign take_vec   = (first_ack && take_ok) ? (BIT0 << req_idx) : '0;
   assign aeoi_clr   = (second_ack && mode_q.auto_eoi && !spur_q) ? (BIT0 << sel_q) : '0;
   assign isr_d      = (isr_eff & ~aeoi_clr) | take_vec;

   always_comb begin
      low_d = LAST;
      if (mode_q.rotate) begin
         if (aeoi_clr != '0)     low_d = sel_q;
         else if (eoi_hit != '0) low_d = isr_idx;
         else                    low_d = low_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         mask_q  <= '0;
         trig_q  <= '0;
         base_q  <= '0;
         isr_q   <= '0;
         low_q   <= LAST;
         phase_q <= 1'b0;
         sel_q   <= LAST;
         spur_q  <= 1'b0;
         vec_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         isr_q <= isr_d;
         low_q <= low_d;
         vld_q <= second_ack;
         if (ack_pulse) phase_q <= ~phase_q;
         if (first_ack) begin
            sel_q  <= take_ok ? req_idx : LAST;
            spur_q <= !take_ok;
         end
         if (second_ack) vec_q <= base_q + VEC_W'(sel_q);
         if (cfg_we) begin
            case (cfg_addr)
               CFG_MODE: mode_q <= pic_mode_t'(cfg_wdata[1:0]);
               CFG_MASK: mask_q <= cfg_wdata[NUM_LINES-1:0];
               CFG_TRIG: trig_q <= cfg_wdata[NUM_LINES-1:0];
               default:  base_q <= cfg_wdata[VEC_W-1:0];
            endcase
         end
      end
   end

   assign vec_out   = vec_q;
   assign vec_valid = vld_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int unsigned N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ack_pulse,
   input logic         eoi_cmd,
   input logic         int_out,
   input logic         vec_valid,
   input logic         phase_q,
   input logic [N-1:0] mask_q,
   input logic [N-1:0] irr_q,
   input logic [N-1:0] isr_q
);
   p_int_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr_q & ~mask_q) != '0));

   p_masked_not_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((isr_q & ~$past(isr_q)) & $past(mask_q)) == '0);

   p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(isr_q & ~$past(isr_q)) <= 1);

   p_vec_after_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ($past(ack_pulse) && $past(phase_q)));

   p_eoi_drops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_cmd && isr_q != '0 && !ack_pulse) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

   p_spurious_keeps_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pulse && !phase_q && !int_out && !eoi_cmd) |=> (isr_q == $past(isr_q)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack_pulse(ack_pulse), .eoi_cmd(eoi_cmd),
   .int_out(int_out), .vec_valid(vec_valid), .phase_q(phase_q),
   .mask_q(mask_q), .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq_in;
   logic       cfg_we;
   logic [1:0] cfg_addr;
   logic [7:0] cfg_wdata;
   logic       eoi_cmd, ack_pulse;
   logic       int_out, vec_valid;
   logic [7:0] vec_out;
   int         n_chk = 0;
   int         n_bad = 0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .eoi_cmd(eoi_cmd),
      .ack_pulse(ack_pulse), .int_out(int_out), .vec_out(vec_out),
      .vec_valid(vec_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      eoi_cmd = 1'b0; ack_pulse = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cfg(input logic [1:0] a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_irq(input logic [7:0] v);
      irq_in = v;
      @(negedge clk);
   endtask

   task automatic eoi();
      eoi_cmd = 1'b1;
      @(negedge clk);
      eoi_cmd = 1'b0;
   endtask

   task automatic ack_once();
      ack_pulse = 1'b1;
      @(negedge clk);
      ack_pulse = 1'b0;
   endtask

   task automatic ack_pair(input string req, input logic [7:0] exp_vec);
      ack_once();
      ack_once();
      chk({req, " vec_valid"}, vec_valid, 1);
      chk({req, " vector"}, vec_out, exp_vec);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 int_out", int_out, 0);
      chk("R1 vec_valid", vec_valid, 0);
      ack_pair("R11 idle", 8'h07);
   endtask

   task automatic t_fixed();
      do_reset();
      cfg(2'd3, 8'h20);
      set_irq(8'h44);
      chk("R5 int_out", int_out, 1);
      ack_pair("R5 first", 8'h22);
      chk("R6 lower blocked", int_out, 0);
      @(negedge clk);
      chk("R7 vec_valid one cycle", vec_valid, 0);
      eoi();
      chk("R8 after eoi", int_out, 1);
      ack_pair("R5 second", 8'h26);
   endtask

   task automatic t_nest();
      do_reset();
      set_irq(8'h04);
      ack_pair("R7 line2", 8'h02);
      set_irq(8'h24);
      chk("R6 line5 under 2", int_out, 0);
      set_irq(8'h26);
      chk("R6 line1 nests", int_out, 1);
      ack_pair("R6 nested", 8'h01);
      eoi();
      chk("R8 top cleared, 2 stays", int_out, 0);
      eoi();
      chk("R8 second eoi", int_out, 1);
      ack_pair("R8 line5", 8'h05);
      eoi();
      eoi();
      chk("R8 empty eoi", int_out, 0);
   endtask

   task automatic t_edge();
      do_reset();
      set_irq(8'h01);
      ack_pair("R2 line0", 8'h00);
      eoi();
      chk("R2 held high no repeat", int_out, 0);
      set_irq(8'h00);
      set_irq(8'h01);
      chk("R2 new edge", int_out, 1);
   endtask

   task automatic t_mask();
      do_reset();
      cfg(2'd1, 8'h08);
      set_irq(8'h08);
      chk("R4 masked", int_out, 0);
      ack_pair("R4 masked ack", 8'h07);
      cfg(2'd1, 8'h00);
      chk("R4 unmasked", int_out, 1);
      ack_pair("R4 taken", 8'h03);
   endtask

   task automatic t_level();
      do_reset();
      cfg(2'd2, 8'h10);
      cfg(2'd3, 8'hFE);
      set_irq(8'h10);
      chk("R3 request", int_out, 1);
      ack_pair("R7 wrap", 8'h02);
      chk("R3 own line in service", int_out, 0);
      eoi();
      @(negedge clk);
      chk("R3 re-request", int_out, 1);
      set_irq(8'h00);
      chk("R3 drop", int_out, 0);
   endtask

   task automatic t_aeoi();
      do_reset();
      cfg(2'd0, 8'h02);
      set_irq(8'h02);
      ack_pair("R9 line1", 8'h01);
      set_irq(8'h22);
      chk("R9 no eoi needed", int_out, 1);
      ack_pair("R9 line5", 8'h05);
   endtask

   task automatic t_rotate();
      do_reset();
      cfg(2'd0, 8'h01);
      set_irq(8'h28);
      ack_pair("R10 first", 8'h03);
      eoi();
      set_irq(8'h2A);
      ack_pair("R10 rotated", 8'h05);
      eoi();
      ack_pair("R10 last", 8'h01);
   endtask

   task automatic t_spurious();
      do_reset();
      cfg(2'd3, 8'h40);
      set_irq(8'h40);
      chk("R11 raised", int_out, 1);
      set_irq(8'h00);
      chk("R11 vanished", int_out, 0);
      ack_pair("R11 spurious", 8'h47);
      set_irq(8'h80);
      chk("R11 no in-service", int_out, 1);
   endtask

   task automatic t_collide();
      do_reset();
      set_irq(8'h04);
      ack_pair("R12 line2", 8'h02);
      set_irq(8'h24);
      chk("R12 blocked", int_out, 0);
      eoi_cmd = 1'b1;
      ack_pulse = 1'b1;
      @(negedge clk);
      eoi_cmd = 1'b0;
      ack_pulse = 1'b0;
      ack_once();
      chk("R12 vec_valid", vec_valid, 1);
      chk("R12 vector", vec_out, 8'h05);
      set_irq(8'h64);
      chk("R12 line5 in service", int_out, 0);
      eoi();
      chk("R12 after eoi", int_out, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_fixed();
      t_nest();
      t_edge();
      t_mask();
      t_level();
      t_aeoi();
      t_rotate();
      t_spurious();
      t_collide();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule